// File: doc/BRIEF.md
# Rank Idle Power-Down Controller

This block sits beside a DRAM command scheduler and watches each rank for idleness. Every rank has two idle counters that run while no command reaches that rank. When the short counter reaches its programmed threshold, the rank drops CKE and enters one of several power-down variants. The variant depends on a 3-bit mode field and on whether the rank has a bank open. When the long counter reaches its own threshold, the rank is promoted to self-refresh, provided that feature is enabled.

An activity strobe for a rank, or the shared traffic-pending input, wakes the rank in the same cycle. CKE rises combinationally and both counters restart from zero. The variant chosen on entry is held until the rank wakes. The only change allowed while it is held is promotion to self-refresh. The scheduler reads the per-rank state code and an exit flag that marks the cycle in which a rank leaves a low-power state.

The power-down threshold must be set to at least the worst round-trip time plus the burst length. The block relies on the scheduler to honour this; it does not check it.

Top module: `rank_pdn_ctrl`

## Requirements
- R1: After reset every rank reports state 0 (active) with CKE high and its exit flag low.
- R2: With pd_idle = L, a rank that sees no strobe and no pending traffic keeps CKE high for exactly L cycles after the last wake cycle and enters power-down in the next cycle. A strobe during the count restarts it from zero.
- R3: The state code reports 0 = active, 1 = active power-down, 2 = precharge power-down, 3 = precharge power-down with DLL off, 4 = self-refresh. Mode 2 gives code 2, and modes 6 and 7 give code 3, but only while the rank has no bank open.
- R4: Mode 1 enters code 1 only while a bank is open. Modes 3 and 7 enter code 1 when a bank is open and precharge power-down when all banks are closed. Mode 6 never enters with a bank open, but enters as soon as the banks close once the threshold has passed.
- R5: Mode codes 0, 4 and 5 never enter any power-down state.
- R6: The variant chosen on entry holds while the rank stays idle, even if its bank status changes.
- R7: With sr_en high and sr_idle = S, the rank enters code 4 when S idle cycles have elapsed. Code 4 takes precedence over power-down, promotes a rank that is already in power-down, and is held until a wake.
- R8: With sr_en low, no rank enters self-refresh.
- R9: A strobe on a rank forces code 0 and CKE high in the same cycle. The exit flag is high in that cycle only if the rank was in a low-power state.
- R10: Pending traffic wakes every rank in the same cycle and blocks entry while it is asserted.
- R11: Each rank counts and changes state independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rank_act | input | NRANK | Per-rank command activity strobe |
| bank_open | input | NRANK | Per-rank flag: at least one bank is open |
| traffic_pend | input | 1 | New traffic requested; wakes all ranks |
| pd_mode | input | 3 | Power-down variant selector |
| pd_idle | input | IDLE_W | Idle cycles before power-down |
| sr_idle | input | SR_W | Idle cycles before self-refresh |
| sr_en | input | 1 | Self-refresh enable |
| cke | output | NRANK | Clock enable per rank |
| lp_state | output | 3*NRANK | State code per rank, 3 bits each, rank 0 in the low bits |
| exit_pend | output | NRANK | Rank is leaving a low-power state this cycle |

## Verification
The hardest case to reach is a rank that has already latched a power-down variant and then sees its bank status flip, or whose threshold has passed before the bank status allows entry. Both depend on the counter position, the mode field and the bank status lining up in one cycle. The stimulus reaches these cases with short thresholds and cycle-counted idle runs. It changes bank_open on chosen idle cycles, and it also runs a configuration where the self-refresh threshold is below the power-down threshold, so that the precedence rule is exercised.

// File: rtl/rank_pdn_ctrl.sv
module rank_pdn_ctrl #(
  parameter int NRANK  = 2,
  parameter int IDLE_W = 8,
  parameter int SR_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NRANK-1:0]   rank_act,
  input  logic [NRANK-1:0]   bank_open,
  input  logic               traffic_pend,
  input  logic [2:0]         pd_mode,
  input  logic [IDLE_W-1:0]  pd_idle,
  input  logic [SR_W-1:0]    sr_idle,
  input  logic               sr_en,
  output logic [NRANK-1:0]   cke,
  output logic [3*NRANK-1:0] lp_state,
  output logic [NRANK-1:0]   exit_pend
);
  localparam logic [2:0] ST_ACT = 3'd0;
  localparam logic [2:0] ST_APD = 3'd1;
  localparam logic [2:0] ST_PPD = 3'd2;
  localparam logic [2:0] ST_DLL = 3'd3;
  localparam logic [2:0] ST_SR  = 3'd4;

  logic apd_ok, ppd_ok, dll_off;
  assign apd_ok  = (pd_mode == 3'd1) || (pd_mode == 3'd3) || (pd_mode == 3'd7);
  assign ppd_ok  = (pd_mode == 3'd2) || (pd_mode == 3'd3) || (pd_mode == 3'd6) || (pd_mode == 3'd7);
  assign dll_off = (pd_mode == 3'd6) || (pd_mode == 3'd7);

  for (genvar r = 0; r < NRANK; r++) begin : g_rank
    logic [IDLE_W-1:0] pd_cnt;
    logic [SR_W-1:0]   sr_cnt;
    logic [2:0]        st_q, st_d, pick;
    logic              wake, pd_hit, sr_hit;

    assign wake   = rank_act[r] | traffic_pend;
    assign pd_hit = pd_cnt >= pd_idle;
    assign sr_hit = sr_en && (sr_cnt >= sr_idle);

    always_comb begin
      if (bank_open[r]) pick = apd_ok ? ST_APD : ST_ACT;
      else if (ppd_ok)  pick = dll_off ? ST_DLL : ST_PPD;
      else              pick = ST_ACT;

      if (wake)                st_d = ST_ACT;
      else if (st_q == ST_SR)  st_d = ST_SR;
      else if (sr_hit)         st_d = ST_SR;
      else if (st_q != ST_ACT) st_d = st_q;
      else if (pd_hit)         st_d = pick;
      else                     st_d = ST_ACT;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pd_cnt <= '0;
        sr_cnt <= '0;
        st_q   <= ST_ACT;
      end else begin
        st_q <= st_d;
        if (wake) begin
          pd_cnt <= '0;
          sr_cnt <= '0;
        end else begin
          if (pd_cnt != '1) pd_cnt <= pd_cnt + 1'b1;
          if (sr_cnt != '1) sr_cnt <= sr_cnt + 1'b1;
        end
      end
    end

    assign lp_state[3*r +: 3] = st_d;
    assign cke[r]             = (st_d == ST_ACT);
    assign exit_pend[r]       = wake && (st_q != ST_ACT);
  end
endmodule

// File: rtl/rank_pdn_ctrl_chk.sv
module rank_pdn_ctrl_chk #(
  parameter int NRANK = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NRANK-1:0]   rank_act,
  input logic [NRANK-1:0]   bank_open,
  input logic               traffic_pend,
  input logic [2:0]         pd_mode,
  input logic               sr_en,
  input logic [NRANK-1:0]   cke,
  input logic [3*NRANK-1:0] lp_state,
  input logic [NRANK-1:0]   exit_pend
);
  logic no_pd_mode;
  assign no_pd_mode = (pd_mode == 3'd0) || (pd_mode == 3'd4) || (pd_mode == 3'd5);

  p_pend_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    traffic_pend |-> (&cke));

  for (genvar r = 0; r < NRANK; r++) begin : g_chk
    p_act_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rank_act[r] |-> (cke[r] && lp_state[3*r +: 3] == 3'd0));

    p_exit_after_lp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exit_pend[r] |-> !$past(cke[r]));

    p_sr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state[3*r +: 3] == 3'd4) |=>
        (lp_state[3*r +: 3] == 3'd4) || rank_act[r] || traffic_pend);

    p_apd_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state[3*r +: 3] == 3'd1 && $past(lp_state[3*r +: 3]) == 3'd0) |-> bank_open[r]);

    p_no_pd_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (no_pd_mode && !sr_en && $past(lp_state[3*r +: 3]) == 3'd0) |-> lp_state[3*r +: 3] == 3'd0);
  end
endmodule

bind rank_pdn_ctrl rank_pdn_ctrl_chk #(.NRANK(NRANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .rank_act(rank_act), .bank_open(bank_open),
  .traffic_pend(traffic_pend), .pd_mode(pd_mode), .sr_en(sr_en),
  .cke(cke), .lp_state(lp_state), .exit_pend(exit_pend)
);

// File: tb/rank_pdn_ctrl_test.sv
module rank_pdn_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  rank_act = '0, bank_open = '0;
  logic        traffic_pend = 1'b0;
  logic [2:0]  pd_mode = 3'd2;
  logic [7:0]  pd_idle = 8'd3;
  logic [15:0] sr_idle = 16'd10;
  logic        sr_en = 1'b1;
  logic [1:0]  cke, exit_pend;
  logic [5:0]  lp_state;

  rank_pdn_ctrl #(.NRANK(2), .IDLE_W(8), .SR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .rank_act(rank_act), .bank_open(bank_open),
    .traffic_pend(traffic_pend), .pd_mode(pd_mode), .pd_idle(pd_idle),
    .sr_idle(sr_idle), .sr_en(sr_en), .cke(cke), .lp_state(lp_state),
    .exit_pend(exit_pend));

  always #5 clk = ~clk;

  typedef struct {
    logic [2:0] s0, s1;
    logic [1:0] ex;
    string      tag;
  } exp_t;
  exp_t q[$];
  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 0;

  always @(negedge clk) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      logic [1:0] ek;
      e = q.pop_front();
      ek = {e.s1 == 3'd0, e.s0 == 3'd0};
      vectors++;
      if (lp_state !== {e.s1, e.s0} || cke !== ek || exit_pend !== e.ex) begin
        miscompares++;
        $display("FAIL %s: state=%h cke=%b exit=%b expected state=%h cke=%b exit=%b",
                 e.tag, lp_state, cke, exit_pend, {e.s1, e.s0}, ek, e.ex);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      miscompares++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic step(input logic [1:0] act, input logic pend, input logic [1:0] bo,
                      input logic [2:0] s0, input logic [2:0] s1, input logic [1:0] ex,
                      input string tag);
    exp_t e;
    rank_act = act; traffic_pend = pend; bank_open = bo;
    e.s0 = s0; e.s1 = s1; e.ex = ex; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle0(input int n, input logic [1:0] bo, input logic [2:0] s0, input string tag);
    for (int i = 0; i < n; i++) step(2'b10, 1'b0, bo, s0, 3'd0, 2'b00, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(2'b10, 0, 2'b00, 0, 0, 2'b00, "R1 reset state");
    idle0(2, 2'b00, 0, "R2 before threshold");
    step(2'b10, 0, 2'b00, 2, 0, 2'b00, "R2 R3 ppd entry");
    idle0(6, 2'b00, 2, "R3 ppd hold");
    step(2'b10, 0, 2'b00, 4, 0, 2'b00, "R7 sr promote");
    step(2'b10, 0, 2'b00, 4, 0, 2'b00, "R7 sr hold");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 strobe exit");
    idle0(3, 2'b00, 0, "R2 count");
    step(2'b11, 0, 2'b00, 0, 0, 2'b00, "R9 strobe while active");
    idle0(3, 2'b00, 0, "R2 restart");
    step(2'b10, 0, 2'b00, 2, 0, 2'b00, "R2 entry after restart");
    step(2'b00, 1, 2'b00, 0, 0, 2'b01, "R10 pending wakes");
    step(2'b00, 1, 2'b00, 0, 0, 2'b00, "R10 pending blocks");
    step(2'b00, 1, 2'b00, 0, 0, 2'b00, "R10 pending blocks");
    step(2'b00, 1, 2'b00, 0, 0, 2'b00, "R10 pending blocks");
    step(2'b00, 1, 2'b00, 0, 0, 2'b00, "R10 pending blocks");

    pd_mode = 3'd1;
    idle0(3, 2'b01, 0, "R4 mode1 count");
    step(2'b10, 0, 2'b01, 1, 0, 2'b00, "R4 mode1 apd entry");
    idle0(2, 2'b00, 1, "R6 apd latched");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 exit apd");
    sr_en = 1'b0;
    idle0(12, 2'b00, 0, "R4 R8 mode1 closed no entry");
    step(2'b11, 0, 2'b00, 0, 0, 2'b00, "R9 rewake");

    pd_mode = 3'd3;
    idle0(3, 2'b01, 0, "R4 mode3 count");
    step(2'b10, 0, 2'b01, 1, 0, 2'b00, "R4 mode3 open apd");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 exit");
    idle0(3, 2'b00, 0, "R4 mode3 count");
    step(2'b10, 0, 2'b00, 2, 0, 2'b00, "R4 mode3 closed ppd");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 exit");

    pd_mode = 3'd7;
    idle0(3, 2'b00, 0, "R3 mode7 count");
    step(2'b10, 0, 2'b00, 3, 0, 2'b00, "R3 mode7 dll off");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 exit");

    pd_mode = 3'd6;
    idle0(6, 2'b01, 0, "R4 mode6 open no entry");
    step(2'b10, 0, 2'b00, 3, 0, 2'b00, "R4 mode6 enters on close");
    step(2'b11, 0, 2'b00, 0, 0, 2'b01, "R9 exit");

    pd_mode = 3'd5;
    idle0(7, 2'b00, 0, "R5 mode5 no entry");
    pd_mode = 3'd4;
    idle0(5, 2'b01, 0, "R5 mode4 no entry");
    pd_mode = 3'd0;
    idle0(5, 2'b00, 0, "R5 mode0 no entry");

    pd_mode = 3'd2;
    step(2'b11, 0, 2'b00, 0, 0, 2'b00, "R11 wake both");
    for (int i = 0; i < 3; i++) step(2'b00, 0, 2'b00, 0, 0, 2'b00, "R11 both count");
    step(2'b00, 0, 2'b00, 2, 2, 2'b00, "R11 both ppd");
    step(2'b10, 0, 2'b00, 2, 0, 2'b10, "R11 rank1 wakes alone");
    for (int i = 0; i < 3; i++) step(2'b00, 0, 2'b00, 2, 0, 2'b00, "R11 rank1 recount");
    step(2'b00, 0, 2'b00, 2, 2, 2'b00, "R11 rank1 re-enters");

    sr_en = 1'b1; sr_idle = 16'd2; pd_idle = 8'd5;
    step(2'b11, 0, 2'b00, 0, 0, 2'b11, "R9 wake both");
    for (int i = 0; i < 2; i++) step(2'b00, 0, 2'b00, 0, 0, 2'b00, "R7 count");
    step(2'b00, 0, 2'b00, 4, 4, 2'b00, "R7 sr before pd");
    for (int i = 0; i < 4; i++) step(2'b00, 0, 2'b00, 4, 4, 2'b00, "R7 sr precedence");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule